// File: doc/BRIEF.md
# Lane Operand Permutation Unit

This unit builds two eight-lane operand vectors for a vector multiplier from wider word buffers. Each output lane takes one 32-bit word from its source buffer. The word's index is a base value shared by all lanes, plus a 4-bit displacement that belongs to that lane alone. All eight displacements are packed into one 32-bit control word. Two gather ports work side by side. The X port reads a 16-word or 32-word buffer. The Z port reads its own 8-word buffer, or it can borrow the X buffer. A single call therefore yields both multiplier operands.

Two controls change the Z result. A constant-one control fills the Z lanes with 1.0. A complex mode treats each pair of consecutive words as one (real, imaginary) element and produces four complex lanes per port. An index that runs past the selected buffer depth wraps around, and a sticky flag records that it happened. The request is taken with a valid/ready handshake. The result is registered and held until the consumer takes it.

Top module: `lane_gather_unit`

## Requirements
- R1: After reset, out_valid is 0, oor_sticky is 0 and in_ready is 1.
- R2: In real mode (cplx=0), X lane i is word ((x_start + x_offs[4i+3:4i]) mod depth) of x_buf. Lane i sits at bits [32i+31:32i] of x_lanes, and word j sits at bits [32j+31:32j] of x_buf.
- R3: The X buffer depth is 32 words when x_wide=1 and 16 words when x_wide=0. Words 16 to 31 are never selected when x_wide=0.
- R4: When z_from_x=0, Z lane i is word ((z_start + z_offs[4i+3:4i]) mod 8) of the 8-word z_buf.
- R5: When z_from_x=1, the Z lanes are gathered from x_buf, using the X depth and z_start/z_offs.
- R6: When z_ones=1, every Z word is 32'h3F800000 in real mode. In complex mode, the even Z words are 32'h3F800000 and the odd Z words are 0.
- R7: In complex mode, element k (0 to 3) uses c = (start + offs[4k+3:4k]) mod (depth/2). Output words 2k and 2k+1 are source words 2c and 2c+1. Offset nibbles 4 to 7 are ignored.
- R8: oor_sticky is set when an accepted request has any X index, or any Z index with z_ones=0, that reaches or passes its depth before the wrap. In complex mode the limit is depth/2. Once set, oor_sticky stays 1 until reset.
- R9: A request accepted at a clock edge (in_valid and in_ready) appears on x_lanes/z_lanes with out_valid=1 right after that edge.
- R10: While out_valid=1 and out_ready=0, in_ready is 0 and x_lanes, z_lanes and out_valid hold.
- R11: When a result is taken (out_ready=1) and no new request arrives, out_valid falls at that edge. When a new request arrives at the same edge, it replaces the result without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| x_buf | input | 1024 | X source buffer, 32 words |
| x_wide | input | 1 | 1: X depth 32 words, 0: 16 words |
| x_start | input | 6 | X common base index |
| x_offs | input | 32 | X per-lane 4-bit displacements |
| z_buf | input | 256 | Z source buffer, 8 words |
| z_start | input | 6 | Z common base index |
| z_offs | input | 32 | Z per-lane 4-bit displacements |
| z_from_x | input | 1 | Gather Z from x_buf |
| z_ones | input | 1 | Replace Z lanes by the constant one |
| cplx | input | 1 | Complex pair mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| x_lanes | output | 256 | Gathered X lanes |
| z_lanes | output | 256 | Gathered Z lanes |
| oor_sticky | output | 1 | Sticky index-wrap flag |

## Verification
Two functions can land on the same clock edge: a stalled result being released, and the next request being accepted. The bench provokes this by holding out_ready low while a second request waits on the inputs. It checks that in_ready stays low and the first result stays frozen for several cycles. It then raises out_ready. The pending request must be taken on that same edge, and the second result must appear in the next cycle with out_valid never dropping. A further edge with no request must then clear out_valid.

// File: rtl/lgu_pkg.sv
package lgu_pkg;
    localparam int LANES      = 8;
    localparam int WORD_W     = 32;
    localparam int XWORDS_MAX = 32;
    localparam int ZWORDS     = 8;
    localparam int START_W    = 6;
    localparam int NIB_W      = 4;
    localparam int LG_W       = 3;
    localparam int VEC_W      = LANES * WORD_W;
    localparam logic [WORD_W-1:0] ONE_F32 = 32'h3F800000;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] xl;
        logic [VEC_W-1:0] zl;
        logic             oor;
    } lgu_state_t;
endpackage

// File: rtl/lgu_lane_sel.sv
module lgu_lane_sel #(
    parameter int LANE    = 0,
    parameter int WORDS   = 32,
    parameter int START_W = 6,
    parameter int NIB_W   = 4,
    parameter int LG_W    = 3,
    parameter int WORD_W  = 32
) (
    input  logic [WORDS*WORD_W-1:0] src,
    input  logic [LG_W-1:0]         depth_lg,
    input  logic [START_W-1:0]      start,
    input  logic [8*NIB_W-1:0]      offs,
    input  logic                    cplx,
    output logic [WORD_W-1:0]       word,
    output logic                    oor
);
    localparam int SUM_W = START_W + 2;
    localparam int IDX_W = $clog2(WORDS);
    localparam int PAIR  = LANE / 2;
    localparam logic PART = 1'(LANE % 2);
    localparam logic [SUM_W-1:0] ONE_S = 1;

    logic [NIB_W-1:0] nib;
    logic [SUM_W-1:0] sum, mask, ent, widx_full;
    logic [LG_W-1:0]  eff_lg;
    logic [IDX_W-1:0] widx;

    always_comb begin
        nib       = cplx ? offs[NIB_W*PAIR +: NIB_W] : offs[NIB_W*LANE +: NIB_W];
        sum       = SUM_W'(start) + SUM_W'(nib);
        eff_lg    = cplx ? (depth_lg - LG_W'(1)) : depth_lg;
        mask      = (ONE_S << eff_lg) - ONE_S;
        ent       = sum & mask;
        oor       = (sum & ~mask) != '0;
        widx_full = cplx ? ((ent << 1) | SUM_W'(PART)) : ent;
        widx      = widx_full[IDX_W-1:0];
        word      = src[widx*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/lgu_port.sv
module lgu_port #(
    parameter int WORDS   = 32,
    parameter int LANES   = 8,
    parameter int START_W = 6,
    parameter int NIB_W   = 4,
    parameter int LG_W    = 3,
    parameter int WORD_W  = 32
) (
    input  logic [WORDS*WORD_W-1:0] src,
    input  logic [LG_W-1:0]         depth_lg,
    input  logic [START_W-1:0]      start,
    input  logic [LANES*NIB_W-1:0]  offs,
    input  logic                    cplx,
    output logic [LANES*WORD_W-1:0] lanes,
    output logic                    oor_any
);
    logic [LANES-1:0] lane_oor;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lgu_lane_sel #(
            .LANE(g), .WORDS(WORDS), .START_W(START_W),
            .NIB_W(NIB_W), .LG_W(LG_W), .WORD_W(WORD_W)
        ) u_sel (
            .src(src), .depth_lg(depth_lg), .start(start), .offs(offs),
            .cplx(cplx), .word(lanes[g*WORD_W +: WORD_W]), .oor(lane_oor[g])
        );
    end

    assign oor_any = |lane_oor;
endmodule

// File: rtl/lane_gather_unit.sv
module lane_gather_unit
    import lgu_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [XWORDS_MAX*WORD_W-1:0]   x_buf,
    input  logic                           x_wide,
    input  logic [START_W-1:0]             x_start,
    input  logic [LANES*NIB_W-1:0]         x_offs,
    input  logic [ZWORDS*WORD_W-1:0]       z_buf,
    input  logic [START_W-1:0]             z_start,
    input  logic [LANES*NIB_W-1:0]         z_offs,
    input  logic                           z_from_x,
    input  logic                           z_ones,
    input  logic                           cplx,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [VEC_W-1:0]               x_lanes,
    output logic [VEC_W-1:0]               z_lanes,
    output logic                           oor_sticky
);
    localparam int XLG_WIDE = $clog2(XWORDS_MAX);
    localparam int XLG_NARW = XLG_WIDE - 1;
    localparam int ZLG      = $clog2(ZWORDS);
    localparam int PAD_W    = (XWORDS_MAX - ZWORDS) * WORD_W;

    lgu_state_t state_d, state_q;

    logic [LG_W-1:0]              x_lg, z_lg;
    logic [XWORDS_MAX*WORD_W-1:0] z_src;
    logic [VEC_W-1:0]             x_raw, z_raw;
    logic                         x_oor, z_oor, accept;

    assign x_lg  = x_wide ? LG_W'(XLG_WIDE) : LG_W'(XLG_NARW);
    assign z_lg  = z_from_x ? x_lg : LG_W'(ZLG);
    assign z_src = z_from_x ? x_buf : {{PAD_W{1'b0}}, z_buf};

    lgu_port #(
        .WORDS(XWORDS_MAX), .LANES(LANES), .START_W(START_W),
        .NIB_W(NIB_W), .LG_W(LG_W), .WORD_W(WORD_W)
    ) u_xport (
        .src(x_buf), .depth_lg(x_lg), .start(x_start), .offs(x_offs),
        .cplx(cplx), .lanes(x_raw), .oor_any(x_oor)
    );

    lgu_port #(
        .WORDS(XWORDS_MAX), .LANES(LANES), .START_W(START_W),
        .NIB_W(NIB_W), .LG_W(LG_W), .WORD_W(WORD_W)
    ) u_zport (
        .src(z_src), .depth_lg(z_lg), .start(z_start), .offs(z_offs),
        .cplx(cplx), .lanes(z_raw), .oor_any(z_oor)
    );

    assign in_ready = !state_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d.valid = 1'b1;
            state_d.xl    = x_raw;
            for (int i = 0; i < LANES; i++) begin
                if (z_ones) begin
                    state_d.zl[i*WORD_W +: WORD_W] =
                        (cplx && (i % 2 == 1)) ? '0 : ONE_F32;
                end else begin
                    state_d.zl[i*WORD_W +: WORD_W] = z_raw[i*WORD_W +: WORD_W];
                end
            end
            if (x_oor || (z_oor && !z_ones)) begin
                state_d.oor = 1'b1;
            end
        end else if (out_ready) begin
            state_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.valid;
    assign x_lanes    = state_q.xl;
    assign z_lanes    = state_q.zl;
    assign oor_sticky = state_q.oor;

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(x_lanes) && $stable(z_lanes));

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oor_sticky |=> oor_sticky);

    assert_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && z_ones |=> z_lanes[WORD_W-1:0] == ONE_F32);

    assert_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: tb/lane_gather_unit_tb.sv
module lane_gather_unit_tb;
    typedef struct packed {
        logic [5:0]  xs;
        logic [31:0] xo;
        logic [5:0]  zs;
        logic [31:0] zo;
        logic        wide;
        logic        zfx;
        logic        ones;
        logic        cplx;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{6'd2,  32'h210FEDCB, 6'd7, 32'h76543210, 1'b1, 1'b1, 1'b0, 1'b0},
        '{6'd0,  32'h76543210, 6'd0, 32'h01234567, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd8,  32'h01234567, 6'd0, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd16, 32'hFFFFFFFF, 6'd0, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b0},
        '{6'd3,  32'hFFFFC210, 6'd0, 32'hFFFF3210, 1'b1, 1'b0, 1'b0, 1'b1},
        '{6'd1,  32'h00006543, 6'd2, 32'h00001010, 1'b0, 1'b0, 1'b1, 1'b1}
    };
    localparam string TREQ [NV] = '{"R2 R5", "R2 R4", "R3 R4", "R6", "R7", "R7 R6"};

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b1;
    logic in_ready, out_valid, oor_sticky;
    logic [1023:0] x_buf;
    logic [255:0]  z_buf, x_lanes, z_lanes;
    logic x_wide = 1'b0, z_from_x = 1'b0, z_ones = 1'b0, cplx = 1'b0;
    logic [5:0] x_start = '0, z_start = '0;
    logic [31:0] x_offs = '0, z_offs = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lane_gather_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .x_buf(x_buf), .x_wide(x_wide), .x_start(x_start), .x_offs(x_offs),
        .z_buf(z_buf), .z_start(z_start), .z_offs(z_offs), .z_from_x(z_from_x),
        .z_ones(z_ones), .cplx(cplx), .out_valid(out_valid), .out_ready(out_ready),
        .x_lanes(x_lanes), .z_lanes(z_lanes), .oor_sticky(oor_sticky)
    );

    initial begin
        for (int j = 0; j < 32; j++) x_buf[j*32 +: 32] = 32'hA0000000 + j;
        for (int j = 0; j < 8; j++)  z_buf[j*32 +: 32] = 32'hB0000000 + j;
    end

    task automatic check(input bit ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] model(input bit is_z, input vec_t v);
        logic [255:0] r;
        int depth, st, w, c, nb;
        logic [31:0] base, of;
        depth = (is_z && !v.zfx) ? 8 : (v.wide ? 32 : 16);
        base  = (is_z && !v.zfx) ? 32'hB0000000 : 32'hA0000000;
        st    = is_z ? int'(v.zs) : int'(v.xs);
        of    = is_z ? v.zo : v.xo;
        for (int i = 0; i < 8; i++) begin
            if (is_z && v.ones) begin
                r[i*32 +: 32] = (v.cplx && i % 2 == 1) ? 32'h0 : 32'h3F800000;
            end else begin
                if (v.cplx) begin
                    nb = int'(of[4*(i/2) +: 4]);
                    c  = (st + nb) % (depth / 2);
                    w  = 2 * c + i % 2;
                end else begin
                    nb = int'(of[4*i +: 4]);
                    w  = (st + nb) % depth;
                end
                r[i*32 +: 32] = base + w;
            end
        end
        return r;
    endfunction

    task automatic drive(input vec_t v);
        x_start = v.xs; x_offs = v.xo; z_start = v.zs; z_offs = v.zo;
        x_wide = v.wide; z_from_x = v.zfx; z_ones = v.ones; cplx = v.cplx;
    endtask

    task automatic run_op(input vec_t v, input string req);
        @(negedge clk);
        drive(v);
        in_valid  = 1'b1;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, {req, " R9 valid"}, 256'(out_valid), 256'd1);
        check(x_lanes == model(1'b0, v), {req, " X"}, x_lanes, model(1'b0, v));
        check(z_lanes == model(1'b1, v), {req, " Z"}, z_lanes, model(1'b1, v));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        vec_t va, vb;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", 256'(out_valid), 256'd0);
        check(oor_sticky == 1'b0, "R1 oor", 256'(oor_sticky), 256'd0);
        check(in_ready == 1'b1, "R1 in_ready", 256'(in_ready), 256'd1);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) run_op(TBL[k], TREQ[k]);
        check(oor_sticky == 1'b0, "R8 no false wrap", 256'(oor_sticky), 256'd0);

        // R3 wide depth reaches word 19 without wrap
        va = '{6'd10, 32'h00000009, 6'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0};
        run_op(va, "R3 wide");
        check(oor_sticky == 1'b0, "R8 wide in range", 256'(oor_sticky), 256'd0);

        // R3 narrow depth wraps 19 to 3, sets R8 flag
        va.wide = 1'b0;
        run_op(va, "R3 narrow wrap");
        check(x_lanes[31:0] == 32'hA0000003, "R3 wrap lane0", 256'(x_lanes[31:0]), 256'hA0000003);
        check(oor_sticky == 1'b1, "R8 set", 256'(oor_sticky), 256'd1);

        // R4 Z wraps 8 to 0, flag stays
        va = '{6'd0, 32'h0, 6'd5, 32'h00000003, 1'b0, 1'b0, 1'b0, 1'b0};
        run_op(va, "R4 Z wrap");
        check(z_lanes[31:0] == 32'hB0000000, "R4 wrap lane0", 256'(z_lanes[31:0]), 256'hB0000000);
        run_op(TBL[1], "R8 after");
        check(oor_sticky == 1'b1, "R8 sticky", 256'(oor_sticky), 256'd1);

        // R10 stall, then R11 replace on same edge
        va = TBL[1];
        vb = TBL[2];
        @(negedge clk);
        drive(va);
        in_valid  = 1'b1;
        out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        drive(vb);
        for (int s = 0; s < 3; s++) begin
            check(in_ready == 1'b0, "R10 in_ready low", 256'(in_ready), 256'd0);
            check(out_valid == 1'b1 && x_lanes == model(1'b0, va), "R10 hold X",
                  x_lanes, model(1'b0, va));
            check(z_lanes == model(1'b1, va), "R10 hold Z", z_lanes, model(1'b1, va));
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R11 no gap", 256'(out_valid), 256'd1);
        check(x_lanes == model(1'b0, vb), "R11 replaced X", x_lanes, model(1'b0, vb));
        check(z_lanes == model(1'b1, vb), "R11 replaced Z", z_lanes, model(1'b1, vb));
        @(negedge clk);
        check(out_valid == 1'b0, "R11 drain", 256'(out_valid), 256'd0);

        finish_run();
    end
endmodule